// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is a two-wire bus slave in front of a 2048 x 8 byte store. A bus master reaches the store through a fixed 7-bit device address. The eighth bit of the header byte gives the direction. A write transaction carries a two-byte word address and may carry one data byte. A read transaction returns bytes from an internal address counter. That counter keeps its value from one transaction to the next. A random read is therefore a write header and a word address, then a repeated start and a read header.

SCL and SDA come in as plain inputs and pass through a two-flop synchroniser on the system clock. SDA is driven open-drain: while `sda_oe` is high the pad pulls the line low, and otherwise the line floats high. The bus pins carry no valid/ready handshake, because the bus protocol itself paces every byte.

Top module: `i2c_mem_slave`

## Requirements
- R1: Out of reset, `sda_oe` is low and the slave waits for a start condition.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high, both seen after synchronisation. After either one, the slave has SDA released. A start from any state begins a new header byte.
- R3: The header byte is sent MSB first. Its upper 7 bits must equal DEV_ADDR (default 7'h50) and its bit 0 selects the direction: 1 is a read and 0 is a write. On a match, the slave pulls SDA low for the whole ninth clock.
- R4: On a header mismatch, the slave does not acknowledge. It ignores all further bits until the next start, and the address counter is not changed.
- R5: A write carries two address bytes. The first gives address bits 10..8 in its bits 2..0, and its upper bits are ignored. The second gives bits 7..0. Both are acknowledged, and the counter takes the 11-bit address after the second byte.
- R6: The first data byte of a write is stored at the counter's address and acknowledged, and the counter keeps that exact address. Every later data byte in the same transaction is not acknowledged and not stored.
- R7: A read header with no address phase returns the byte at the counter's address, MSB first. The counter advances by one after each byte sent.
- R8: A repeated start that follows the second address acknowledge is accepted without error and writes nothing. The read that follows returns the byte at the new address.
- R9: If the master holds SDA low on the ninth clock of a read byte, the slave sends the next byte. The counter wraps from 0x7FF to 0x000.
- R10: If the master leaves SDA high on the ninth clock of a read byte, the slave releases SDA. It ignores further SCL clocks until a start or stop, and the counter stays where it is.
- R11: A stop that arrives during the ninth clock of a read ends the read cleanly. The counter points one past the byte just sent.
- R12: The slave changes `sda_oe` only while the synchronised SCL is low. It samples master bits on the rising edge of SCL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Open-drain enable: high pulls SDA low |

## Verification
On every cycle, the assertions check these rules: SDA moves only while the synchronised SCL is low, the line is released after each start or stop, and a transaction stores at most one byte. They also check that the address counter moves only by a load or by a single step with wrap. Other behaviour shows only in the bench's transactions. That covers which header gets an acknowledge, which byte comes back after a write, a repeated start or a wrap, and that the counter holds still after a NACK, a foreign address or a stop on the ninth clock. The bench's bus model predicts the level of the slave's drive during every SCL high phase and compares it on each clock.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_RX,
    PH_ACKW,
    PH_ACKD,
    PH_TX,
    PH_TEND,
    PH_TACK,
    PH_TNEXT,
    PH_HOLD
  } phase_t;

  typedef enum logic [1:0] {
    RK_DEV,
    RK_AHI,
    RK_ALO,
    RK_DAT
  } rxk_t;

endpackage

// File: rtl/i2cm_line_sync.sv
module i2cm_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic scl_q,
  output logic sda_s,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              sda_q;

  genvar g;
  for (g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff[0] <= 1'b1;
          sda_ff[0] <= 1'b1;
        end else begin
          scl_ff[0] <= scl_i;
          sda_ff[0] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff[g] <= 1'b1;
          sda_ff[g] <= 1'b1;
        end else begin
          scl_ff[g] <= scl_ff[g-1];
          sda_ff[g] <= sda_ff[g-1];
        end
      end
    end
  end

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  // Line conditions: SDA moving while SCL stays high across both samples.
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2cm_store.sv
module i2cm_store #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
#(
  parameter int          AW       = 11,
  parameter int          DW       = 8,
  parameter logic [6:0]  DEV_ADDR = 7'h50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          scl_q,
  input  logic          sda_s,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [DW-1:0] rdata,
  output logic          sda_oe,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic [AW-1:0] ptr,
  output logic          ptr_load
);

  localparam int HI_W = AW - DW;
  localparam int CW   = $clog2(DW);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

  phase_t          phase;
  rxk_t            kind;
  rxk_t            nxt_kind;
  logic [CW-1:0]   cnt;
  logic [DW-1:0]   sh;
  logic [HI_W-1:0] hi;
  logic            go_tx;
  logic            wrote;
  logic            scl_rise;
  logic            scl_fall;
  logic [DW-1:0]   byte_in;

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign byte_in  = {sh[DW-2:0], sda_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      kind      <= RK_DEV;
      nxt_kind  <= RK_DEV;
      cnt       <= '0;
      sh        <= '0;
      hi        <= '0;
      go_tx     <= 1'b0;
      wrote     <= 1'b0;
      sda_oe    <= 1'b0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      ptr       <= '0;
      ptr_load  <= 1'b0;
    end else begin
      mem_we   <= 1'b0;
      ptr_load <= 1'b0;
      if (start_det) begin
        phase  <= PH_RX;
        kind   <= RK_DEV;
        cnt    <= '0;
        sda_oe <= 1'b0;
        wrote  <= 1'b0;
      end else if (stop_det) begin
        phase  <= PH_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (phase)
          PH_RX: if (scl_rise) begin
            sh  <= byte_in;
            cnt <= cnt + 1'b1;
            if (cnt == LAST_BIT) begin
              cnt <= '0;
              case (kind)
                RK_DEV: begin
                  if (byte_in[7:1] == DEV_ADDR) begin
                    phase    <= PH_ACKW;
                    go_tx    <= byte_in[0];
                    nxt_kind <= RK_AHI;
                  end else begin
                    phase <= PH_IDLE;
                  end
                end
                RK_AHI: begin
                  hi       <= byte_in[HI_W-1:0];
                  go_tx    <= 1'b0;
                  nxt_kind <= RK_ALO;
                  phase    <= PH_ACKW;
                end
                RK_ALO: begin
                  ptr      <= {hi, byte_in};
                  ptr_load <= 1'b1;
                  go_tx    <= 1'b0;
                  nxt_kind <= RK_DAT;
                  phase    <= PH_ACKW;
                end
                default: begin
                  if (!wrote) begin
                    mem_we    <= 1'b1;
                    mem_wdata <= byte_in;
                    wrote     <= 1'b1;
                    go_tx     <= 1'b0;
                    nxt_kind  <= RK_DAT;
                    phase     <= PH_ACKW;
                  end else begin
                    phase <= PH_HOLD;
                  end
                end
              endcase
            end
          end
          PH_ACKW: if (scl_fall) begin
            sda_oe <= 1'b1;
            phase  <= PH_ACKD;
          end
          PH_ACKD: if (scl_fall) begin
            cnt <= '0;
            if (go_tx) begin
              sh     <= rdata;
              sda_oe <= ~rdata[DW-1];
              phase  <= PH_TX;
            end else begin
              sda_oe <= 1'b0;
              kind   <= nxt_kind;
              phase  <= PH_RX;
            end
          end
          PH_TX: begin
            if (scl_rise) begin
              sh  <= sh << 1;
              cnt <= cnt + 1'b1;
              if (cnt == LAST_BIT) begin
                cnt   <= '0;
                ptr   <= ptr + 1'b1;
                phase <= PH_TEND;
              end
            end else if (scl_fall) begin
              sda_oe <= ~sh[DW-1];
            end
          end
          PH_TEND: if (scl_fall) begin
            sda_oe <= 1'b0;
            phase  <= PH_TACK;
          end
          PH_TACK: if (scl_rise) begin
            phase <= sda_s ? PH_HOLD : PH_TNEXT;
          end
          PH_TNEXT: if (scl_fall) begin
            sh     <= rdata;
            sda_oe <= ~rdata[DW-1];
            cnt    <= '0;
            phase  <= PH_TX;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave #(
  parameter int         AW          = 11,
  parameter int         DW          = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);

  logic          scl_s;
  logic          scl_q;
  logic          sda_s;
  logic          start_det;
  logic          stop_det;
  logic          mem_we;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] rdata;
  logic [AW-1:0] ptr;
  logic          ptr_load;

  i2cm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .scl_q     (scl_q),
    .sda_s     (sda_s),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2cm_ctrl #(.AW(AW), .DW(DW), .DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .scl_q     (scl_q),
    .sda_s     (sda_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rdata     (rdata),
    .sda_oe    (sda_oe),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .ptr       (ptr),
    .ptr_load  (ptr_load)
  );

  i2cm_store #(.AW(AW), .DW(DW)) u_store (
    .clk   (clk),
    .we    (mem_we),
    .waddr (ptr),
    .wdata (mem_wdata),
    .raddr (ptr),
    .rdata (rdata)
  );

endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          sda_oe,
  input logic          start_det,
  input logic          stop_det,
  input logic          mem_we,
  input logic [AW-1:0] ptr,
  input logic          ptr_load
);

  logic seen_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         seen_we <= 1'b0;
    else if (start_det) seen_we <= 1'b0;
    else if (mem_we)    seen_we <= 1'b1;
  end

  // R12
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

  // R2
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R2
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);

  // R6
  single_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !seen_we);

  // R9
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ptr != $past(ptr)) && !ptr_load) |-> (AW'(ptr - $past(ptr)) == AW'(1)));

endmodule

bind i2c_mem_slave i2c_mem_slave_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_s     (scl_s),
  .sda_oe    (sda_oe),
  .start_det (start_det),
  .stop_det  (stop_det),
  .mem_we    (mem_we),
  .ptr       (ptr),
  .ptr_load  (ptr_load)
);

// File: tb/sim_i2c_mem_slave.sv
module sim_i2c_mem_slave;

  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe;
  wire  sda_line;

  assign sda_line = ~(m_low | sda_oe);

  always #2 clk = ~clk;

  i2c_mem_slave u0 (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl),
    .sda_i  (sda_line),
    .sda_oe (sda_oe)
  );

  int   tests = 0;
  int   fails = 0;
  bit   done = 1'b0;
  logic exp_oe = 1'b0;
  bit   chk_on = 1'b0;
  int   line_errs = 0;

  logic [7:0] mm [int];
  int         mptr = 0;

  // Per-clock reference: expected slave drive during every SCL high phase.
  always @(negedge clk) begin
    if (chk_on && !done && (sda_oe !== exp_oe)) begin
      fails++;
      line_errs++;
      if (line_errs < 10)
        $display("FAIL R12 line model: sda_oe actual %0b expected %0b at %0t", sda_oe, exp_oe, $time);
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int expv, input string what);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  task automatic clk_bit(input bit drive_low, input logic expd, output logic seen);
    m_low = drive_low;
    wt(Q);
    scl = 1'b1;
    exp_oe = expd;
    chk_on = 1'b1;
    wt(Q);
    seen = sda_line;
    wt(Q);
    chk_on = 1'b0;
    scl = 1'b0;
    wt(Q);
  endtask

  task automatic bus_start();
    m_low = 1'b0; wt(Q);
    scl = 1'b1;   wt(Q);
    m_low = 1'b1; wt(Q);
    scl = 1'b0;   wt(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wt(Q);
    scl = 1'b1;   wt(Q);
    m_low = 1'b0; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(~b[i], 1'b0, s);
    clk_bit(1'b0, exp_ack, s);
    check(s == !exp_ack, req, int'(s), int'(!exp_ack), "ninth-clock SDA level");
  endtask

  task automatic recv_byte(input bit mack, input logic [7:0] expv, input string req);
    logic s;
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b0, ~expv[i], s);
      got[i] = s;
    end
    clk_bit(mack, 1'b0, s);
    check(got == expv, req, int'(got), int'(expv), "read byte");
  endtask

  task automatic recv8_then_stop(input logic [7:0] expv, input string req);
    logic s;
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b0, ~expv[i], s);
      got[i] = s;
    end
    check(got == expv, req, int'(got), int'(expv), "read byte before ninth-clock stop");
    bus_stop();
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    bus_start();
    send_byte(8'hA0, 1'b1, "R3");
    send_byte(8'(a >> 8), 1'b1, "R5");
    send_byte(8'(a), 1'b1, "R5");
    send_byte(d, 1'b1, "R6");
    bus_stop();
    mm[a] = d;
    mptr = a;
  endtask

  task automatic rr_begin(input int a);
    bus_start();
    send_byte(8'hA0, 1'b1, "R3");
    send_byte(8'(a >> 8), 1'b1, "R5");
    send_byte(8'(a), 1'b1, "R5");
    bus_start();
    send_byte(8'hA1, 1'b1, "R8");
    mptr = a;
  endtask

  task automatic cur_begin();
    bus_start();
    send_byte(8'hA1, 1'b1, "R7");
  endtask

  task automatic rd_next(input bit mack, input string req);
    logic [7:0] e;
    e = mm[mptr];
    recv_byte(mack, e, req);
    mptr = (mptr + 1) % 2048;
  endtask

  initial begin
    wt(3);
    check(sda_oe == 1'b0, "R1", int'(sda_oe), 0, "sda_oe in reset");
    wt(10);
    rst_n = 1'b1;
    wt(20);
    check(sda_oe == 1'b0, "R1", int'(sda_oe), 0, "sda_oe after reset");

    // Writes set the counter exactly; current read returns that byte (R5, R6, R7)
    wr(32'h123, 8'hA5);
    wr(32'h124, 8'h3C);
    cur_begin(); rd_next(1'b0, "R7"); bus_stop();

    // Random read via repeated start; no store happens (R8); counter advances (R7)
    rr_begin(32'h123); rd_next(1'b0, "R8"); bus_stop();
    cur_begin(); rd_next(1'b0, "R7"); bus_stop();

    // Second data byte is refused and not stored (R6)
    wr(32'h201, 8'h00);
    bus_start();
    send_byte(8'hA0, 1'b1, "R3");
    send_byte(8'h02, 1'b1, "R5");
    send_byte(8'h00, 1'b1, "R5");
    send_byte(8'h5A, 1'b1, "R6");
    send_byte(8'h77, 1'b0, "R6");
    bus_stop();
    mm[32'h200] = 8'h5A;
    mptr = 32'h200;
    cur_begin(); rd_next(1'b1, "R6"); rd_next(1'b0, "R6"); bus_stop();

    // Sequential read across the top of the address space (R9)
    wr(32'h001, 8'h44);
    wr(32'h7FE, 8'h11);
    wr(32'h7FF, 8'h22);
    wr(32'h000, 8'h33);
    rr_begin(32'h7FE);
    rd_next(1'b1, "R9"); rd_next(1'b1, "R9"); rd_next(1'b0, "R9");
    bus_stop();
    check(mptr == 1, "R9", mptr, 1, "model counter after wrap");
    cur_begin(); rd_next(1'b0, "R9"); bus_stop();

    // Foreign address: no acknowledge, counter untouched (R4)
    wr(32'h002, 8'h66);
    bus_start();
    send_byte(8'hA2, 1'b0, "R4");
    send_byte(8'h01, 1'b0, "R4");
    send_byte(8'h23, 1'b0, "R4");
    bus_stop();
    bus_start();
    send_byte(8'hA3, 1'b0, "R4");
    recv_byte(1'b0, 8'hFF, "R4");
    bus_stop();
    cur_begin(); rd_next(1'b0, "R4"); bus_stop();

    // NACK on ninth clock: slave silent for extra clocks, counter holds (R10)
    rr_begin(32'h123);
    rd_next(1'b0, "R10");
    recv_byte(1'b0, 8'hFF, "R10");
    recv_byte(1'b1, 8'hFF, "R10");
    bus_stop();
    cur_begin(); rd_next(1'b0, "R10"); bus_stop();

    // Stop during the ninth clock of a read (R11)
    rr_begin(32'h7FF);
    recv8_then_stop(mm[32'h7FF], "R11");
    mptr = 0;
    cur_begin(); rd_next(1'b0, "R11"); bus_stop();

    // Line released after stop (R2)
    wt(Q);
    check(sda_oe == 1'b0, "R2", int'(sda_oe), 0, "sda_oe after stop");

    tests++;
    if (line_errs != 0)
      $display("FAIL R12 line model: actual %0d mismatching clocks expected 0", line_errs);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule